// File: doc/BRIEF.md
# Extended-Register Adder with Condition Flags

This block executes one add in which the second operand is first widened and then shifted before it meets the first operand. The widening takes an 8-, 16-, 32- or 64-bit slice from the low end of the second source value and fills the upper bits with zeros or with copies of the slice's sign bit. The widened value is then moved left by zero to four places. The sum is formed at either 32 or 64 bits, and a four-bit negative/zero/carry/overflow vector is produced at the same width.

The block takes a 32-bit instruction word and three 64-bit values: the value read for the first source index, the value read for the second source index, and the current stack pointer. Index 31 is handled inside the block. As the first source it selects the stack pointer. As the second source it reads as zero.

The outputs are registered and show one clock after the inputs are sampled. They carry the sum, the destination index, the flag vector, a register write request and an undefined-instruction indication. A destination index of 31 turns the add into a compare: the flags update, but no write is requested. A shift code above four is illegal. It raises the undefined indication, requests no write and leaves the flags as they were.

Top module: `addx_unit`

## Requirements
- R1: Fields are read from fixed instruction bits: width select at 31, second source index at 20:16, extend code at 15:13, shift code at 12:10, first source index at 9:5, destination index at 4:0. Bits 30:21 are ignored. `rd_idx` echoes bits 4:0.
- R2: In the extend code, bits [1:0] pick the source size (00 = 8, 01 = 16, 10 = 32, 11 = 64 bits) and bit [2] picks the fill (0 = zeros, 1 = sign copies).
- R3: The extended value is shifted left by the shift code (0 to 4). Bits moved above the operating width are discarded before the add.
- R4: A shift code of 5, 6 or 7 sets `undef`, clears `wr_en`, drives `result` to zero and keeps `flags` at their previous value.
- R5: Width select 0 computes at 32 bits, with `result[63:32]` zero. Width select 1 computes at 64 bits. In 32-bit mode, extend codes 011 and 111 pass the low 32 bits through unchanged.
- R6: A first source index of 31 uses `sp_val`, cut to the operating width, in place of `rn_val`.
- R7: A second source index of 31 gives a second operand of zero, whatever `rm_val` holds.
- R8: `flags` = {N,Z,C,V} in bits [3:0]. N is the result's top bit at the operating width. Z is set when the result is zero at that width. C is the unsigned carry out of that width, with a carry-in of 0. V is set when the two operands agree in sign and the result does not.
- R9: A destination index of 31 with a legal shift updates `flags` and `result` but leaves `wr_en` low. Any other destination with a legal shift raises `wr_en`.
- R10: Outputs are registered: they reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word |
| rn_val | input | 64 | Value read for the first source index |
| rm_val | input | 64 | Value read for the second source index |
| sp_val | input | 64 | Current stack pointer |
| result | output | 64 | Sum, zero-filled above the operating width |
| rd_idx | output | 5 | Destination index |
| flags | output | 4 | {N,Z,C,V} |
| wr_en | output | 1 | Register write request |
| undef | output | 1 | Illegal shift code seen |

## Verification
Random operands sweep every extend code against every legal shift at both widths. This separates zero fill from sign fill, and it shows whether high bits are discarded correctly when a 32-bit shift pushes them out. Directed cases feed a byte with its top bit set under both fills. They also force signed overflow, unsigned carry into a zero result, and a shift that drops set bits at 32 bits. Index 31 is placed in each source position to tell the stack-pointer path from the zero path, and in the destination position to tell a compare from a write. Illegal shift codes follow an operation with known flags, so a flag change caused by the illegal code becomes visible.

// File: rtl/addx_pkg.sv
package addx_pkg;

    typedef enum logic [1:0] {
        OPC_WRITE = 2'd0,
        OPC_CMP   = 2'd1,
        OPC_UNDEF = 2'd2
    } opc_e;

    typedef struct packed {
        logic       wide;
        logic [4:0] rm;
        logic [2:0] ext;
        logic [2:0] sh;
        logic [4:0] rn;
        logic [4:0] rd;
    } fields_t;

    localparam logic [4:0] IDX_SPECIAL = 5'd31;

endpackage

// File: rtl/addx_decode.sv
module addx_decode
    import addx_pkg::*;
#(
    parameter int SHIFT_MAX = 4
) (
    input  logic [31:0] instr,
    output fields_t     fld,
    output opc_e        opc
);

    logic [9:0] unused_opbits;
    assign unused_opbits = instr[30:21];

    always_comb begin
        fld.wide = instr[31];
        fld.rm   = instr[20:16];
        fld.ext  = instr[15:13];
        fld.sh   = instr[12:10];
        fld.rn   = instr[9:5];
        fld.rd   = instr[4:0];
    end

    always_comb begin
        if (int'(fld.sh) > SHIFT_MAX)
            opc = OPC_UNDEF;
        else if (fld.rd == IDX_SPECIAL)
            opc = OPC_CMP;
        else
            opc = OPC_WRITE;
    end

endmodule

// File: rtl/addx_opsel.sv
module addx_opsel
    import addx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  fields_t            fld,
    input  logic [DATA_W-1:0]  rn_val,
    input  logic [DATA_W-1:0]  rm_val,
    input  logic [DATA_W-1:0]  sp_val,
    output logic [DATA_W-1:0]  op_a,
    output logic [DATA_W-1:0]  op_b
);

    localparam int HALF_W = DATA_W / 2;
    localparam int QTR_W  = DATA_W / 4;
    localparam int OCT_W  = DATA_W / 8;

    logic [DATA_W-1:0] raw_b;
    logic [DATA_W-1:0] ext_b;
    logic [DATA_W-1:0] shf_b;
    logic [DATA_W-1:0] sel_a;
    logic              fill;

    assign raw_b = (fld.rm == IDX_SPECIAL) ? '0 : rm_val;
    assign sel_a = (fld.rn == IDX_SPECIAL) ? sp_val : rn_val;

    always_comb begin
        fill  = 1'b0;
        ext_b = raw_b;
        unique case (fld.ext[1:0])
            2'b00: begin
                fill  = fld.ext[2] & raw_b[OCT_W-1];
                ext_b = {{(DATA_W-OCT_W){fill}}, raw_b[OCT_W-1:0]};
            end
            2'b01: begin
                fill  = fld.ext[2] & raw_b[QTR_W-1];
                ext_b = {{(DATA_W-QTR_W){fill}}, raw_b[QTR_W-1:0]};
            end
            2'b10: begin
                fill  = fld.ext[2] & raw_b[HALF_W-1];
                ext_b = {{(DATA_W-HALF_W){fill}}, raw_b[HALF_W-1:0]};
            end
            default: begin
                fill  = 1'b0;
                ext_b = raw_b;
            end
        endcase
    end

    assign shf_b = ext_b << fld.sh;

    always_comb begin
        op_a = sel_a;
        op_b = shf_b;
        if (!fld.wide) begin
            op_a[DATA_W-1:HALF_W] = '0;
            op_b[DATA_W-1:HALF_W] = '0;
        end
    end

endmodule

// File: rtl/addx_sum.sv
module addx_sum #(
    parameter int DATA_W = 64
) (
    input  logic              wide,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] sum,
    output logic [3:0]        nzcv
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] full;
    logic            sa, sb, sr, cout;

    assign full = {1'b0, op_a} + {1'b0, op_b};

    always_comb begin
        sum = full[DATA_W-1:0];
        if (wide) begin
            sa   = op_a[DATA_W-1];
            sb   = op_b[DATA_W-1];
            sr   = full[DATA_W-1];
            cout = full[DATA_W];
        end else begin
            sum[DATA_W-1:HALF_W] = '0;
            sa   = op_a[HALF_W-1];
            sb   = op_b[HALF_W-1];
            sr   = full[HALF_W-1];
            cout = full[HALF_W];
        end
        nzcv[3] = sr;
        nzcv[2] = (sum == '0);
        nzcv[1] = cout;
        nzcv[0] = (sa == sb) && (sr != sa);
    end

endmodule

// File: rtl/addx_unit.sv
module addx_unit
    import addx_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int SHIFT_MAX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] rn_val,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [DATA_W-1:0] sp_val,
    output logic [DATA_W-1:0] result,
    output logic [4:0]        rd_idx,
    output logic [3:0]        flags,
    output logic              wr_en,
    output logic              undef
);

    fields_t           fld;
    opc_e              opc;
    logic [DATA_W-1:0] op_a, op_b, sum;
    logic [3:0]        nzcv;

    logic [DATA_W-1:0] res_d;
    logic [3:0]        flg_d;
    logic              wr_d, und_d;

    addx_decode #(.SHIFT_MAX(SHIFT_MAX)) u_dec (
        .instr (instr),
        .fld   (fld),
        .opc   (opc)
    );

    addx_opsel #(.DATA_W(DATA_W)) u_opsel (
        .fld    (fld),
        .rn_val (rn_val),
        .rm_val (rm_val),
        .sp_val (sp_val),
        .op_a   (op_a),
        .op_b   (op_b)
    );

    addx_sum #(.DATA_W(DATA_W)) u_sum (
        .wide (fld.wide),
        .op_a (op_a),
        .op_b (op_b),
        .sum  (sum),
        .nzcv (nzcv)
    );

    always_comb begin
        res_d = '0;
        flg_d = flags;
        wr_d  = 1'b0;
        und_d = 1'b0;
        unique case (opc)
            OPC_WRITE: begin
                res_d = sum;
                flg_d = nzcv;
                wr_d  = 1'b1;
            end
            OPC_CMP: begin
                res_d = sum;
                flg_d = nzcv;
            end
            OPC_UNDEF: begin
                und_d = 1'b1;
            end
            default: begin
                und_d = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            rd_idx <= '0;
            flags  <= '0;
            wr_en  <= 1'b0;
            undef  <= 1'b0;
        end else begin
            result <= res_d;
            rd_idx <= fld.rd;
            flags  <= flg_d;
            wr_en  <= wr_d;
            undef  <= und_d;
        end
    end

endmodule

// File: rtl/addx_unit_chk.sv
module addx_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       instr,
    input logic [DATA_W-1:0] result,
    input logic [3:0]        flags,
    input logic              wr_en,
    input logic              undef
);

    localparam int HALF_W = DATA_W / 2;

    p_undef_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (!wr_en && result == '0));

    p_undef_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> flags == $past(flags));

    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, undef}));

    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !$past(instr[31])) |-> result[DATA_W-1:HALF_W] == '0);

    p_cmp_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(instr[4:0]) == 5'd31) |-> !wr_en);

    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !undef) |->
            flags[2] == ($past(instr[31]) ? (result == '0)
                                          : (result[HALF_W-1:0] == '0)));

    p_neg_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !undef) |->
            flags[3] == ($past(instr[31]) ? result[DATA_W-1] : result[HALF_W-1]));

endmodule

bind addx_unit addx_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .instr  (instr),
    .result (result),
    .flags  (flags),
    .wr_en  (wr_en),
    .undef  (undef)
);

// File: tb/addx_unit_tb.sv
module addx_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rn_val = '0, rm_val = '0, sp_val = '0;
    logic [63:0] result;
    logic [4:0]  rd_idx;
    logic [3:0]  flags;
    logic        wr_en, undef;

    int total = 0;
    int bad   = 0;
    logic [3:0] exp_flags = '0;

    always #10 clk = ~clk;

    addx_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr(instr),
        .rn_val(rn_val), .rm_val(rm_val), .sp_val(sp_val),
        .result(result), .rd_idx(rd_idx), .flags(flags),
        .wr_en(wr_en), .undef(undef)
    );

    function automatic logic [31:0] mk(input logic sf, input logic [4:0] m,
                                       input logic [2:0] e, input logic [2:0] s,
                                       input logic [4:0] n, input logic [4:0] d,
                                       input logic [9:0] other);
        return {sf, other, m, e, s, n, d};
    endfunction

    function automatic void ref_calc(input logic [31:0] ins, input logic [63:0] rn,
                                     input logic [63:0] rm, input logic [63:0] sp,
                                     output logic [63:0] res, output logic [3:0] nzcv);
        logic [63:0] a, b0, b;
        logic [64:0] s65;
        logic [32:0] s33;
        a  = (ins[9:5] == 5'd31) ? sp : rn;
        b0 = (ins[20:16] == 5'd31) ? 64'd0 : rm;
        case (ins[15:13])
            3'd0: b = b0 & 64'hFF;
            3'd1: b = b0 & 64'hFFFF;
            3'd2: b = b0 & 64'hFFFF_FFFF;
            3'd3: b = b0;
            3'd4: b = {{56{b0[7]}}, b0[7:0]};
            3'd5: b = {{48{b0[15]}}, b0[15:0]};
            3'd6: b = {{32{b0[31]}}, b0[31:0]};
            default: b = b0;
        endcase
        b = b << ins[12:10];
        if (ins[31]) begin
            s65 = {1'b0, a} + {1'b0, b};
            res = s65[63:0];
            nzcv = {res[63], res == 64'd0, s65[64], (a[63] == b[63]) && (res[63] != a[63])};
        end else begin
            s33 = {1'b0, a[31:0]} + {1'b0, b[31:0]};
            res = {32'd0, s33[31:0]};
            nzcv = {res[31], res[31:0] == 32'd0, s33[32], (a[31] == b[31]) && (res[31] != a[31])};
        end
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic run(input logic [31:0] ins, input logic [63:0] rn,
                       input logic [63:0] rm, input logic [63:0] sp, input string tag);
        logic [63:0] er;
        logic [3:0]  ef;
        logic        legal;
        @(negedge clk);
        instr = ins; rn_val = rn; rm_val = rm; sp_val = sp;
        @(negedge clk);
        legal = (ins[12:10] <= 3'd4);
        ref_calc(ins, rn, rm, sp, er, ef);
        if (legal) exp_flags = ef;
        else er = '0;
        chk(tag, "result", result, er);
        chk(tag, "flags", {60'd0, flags}, {60'd0, exp_flags});
        chk(tag, "wr_en", {63'd0, wr_en}, {63'd0, legal && ins[4:0] != 5'd31});
        chk(tag, "undef", {63'd0, undef}, {63'd0, !legal});
        chk(tag, "rd_idx", {59'd0, rd_idx}, {59'd0, ins[4:0]});
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog R10 got=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "reset result", result, 64'd0);
        chk("R10", "reset misc", {55'd0, rd_idx, flags, wr_en, undef}, 64'd0);
        rst_n = 1'b1;

        // R2: byte with top bit set, zero vs sign fill
        run(mk(1, 5'd2, 3'd0, 3'd0, 5'd1, 5'd3, 10'h159), 64'd0, 64'h1234_0080, 64'd0, "R2");
        run(mk(1, 5'd2, 3'd4, 3'd0, 5'd1, 5'd3, 10'h159), 64'd0, 64'h1234_0080, 64'd0, "R2");
        // R5: 32-bit mode, 64-bit source passes low word
        run(mk(0, 5'd2, 3'd7, 3'd1, 5'd1, 5'd3, 10'h159), 64'h5, 64'hAAAA_0000_8000_0001, 64'd0, "R5");
        // R3: shift drops set bits above 32
        run(mk(0, 5'd2, 3'd2, 3'd4, 5'd1, 5'd3, 10'h159), 64'd0, 64'hF000_0001, 64'd0, "R3");
        // R6: first source 31 picks stack pointer, both widths
        run(mk(1, 5'd2, 3'd3, 3'd0, 5'd31, 5'd3, 10'h159), 64'h1111, 64'd1, 64'hFFFF_0000_1234_5678, "R6");
        run(mk(0, 5'd2, 3'd3, 3'd0, 5'd31, 5'd3, 10'h159), 64'h1111, 64'd1, 64'hFFFF_0000_1234_5678, "R6");
        // R7: second source 31 is zero
        run(mk(1, 5'd31, 3'd3, 3'd2, 5'd1, 5'd3, 10'h159), 64'h77, 64'hDEAD_BEEF, 64'd0, "R7");
        // R8: signed overflow, carry to zero at both widths
        run(mk(1, 5'd2, 3'd3, 3'd0, 5'd1, 5'd3, 10'h159), 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, "R8");
        run(mk(1, 5'd2, 3'd3, 3'd0, 5'd1, 5'd3, 10'h159), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, "R8");
        run(mk(0, 5'd2, 3'd2, 3'd0, 5'd1, 5'd3, 10'h159), 64'hFFFF_FFFF, 64'd1, 64'd0, "R8");
        // R9: compare form
        run(mk(1, 5'd2, 3'd3, 3'd0, 5'd1, 5'd31, 10'h159), 64'h8000_0000_0000_0000, 64'd5, 64'd0, "R9");
        // R4: illegal shifts after known flags
        for (int k = 5; k < 8; k++) begin
            run(mk(1, 5'd2, 3'd3, 3'd0, 5'd1, 5'd3, 10'h159), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, "R8");
            run(mk(1, 5'd2, 3'd3, 3'(k), 5'd1, 5'd4, 10'h159), 64'd1, 64'd2, 64'd0, "R4");
        end

        // R1 R2 R3 R5 R8: sweep with random operands and random ignored bits
        for (int i = 0; i < 800; i++) begin
            logic [4:0] n, m, d;
            n = 5'($urandom_range(0, 31));
            m = 5'($urandom_range(0, 31));
            d = 5'($urandom_range(0, 31));
            run(mk(1'((i / 40) % 2), m, 3'(i % 8), 3'((i / 8) % 5), n, d, 10'($urandom)),
                {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                "R1 R2 R3 R5 R8");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule